// File: doc/BRIEF.md
# Next Program Counter and Branch Resolution Unit

This block owns the program counter of a 32-bit load-store processor and decides, once per clock, which address is fetched next. It looks at the instruction word fetched from the current address and at the two source register values read for it. From these it picks one of four successors: the sequential address, a PC-relative branch target, a region-relative jump target, or a register-held address.

Branches compare the first source register with the second, or the first source register against zero as a signed number. The jump-and-link form also raises a write request toward the register file. The request carries register 31 as the destination and the address of the instruction after the call as the data. The next address is available combinationally for the fetch stage, and the PC register takes it on every rising edge.

Reset is asynchronous and active low. Its release passes through a short synchronizer, so the PC stays at the reset address for a few edges after the reset pin rises.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` equals RESET_PC (0 by default). After `rst_n` rises, `pc` holds RESET_PC through SYNC_STAGES rising edges. It first advances on edge SYNC_STAGES+1.
- R2: Every opcode (bits 31:26) other than 0x00, 0x02 to 0x07 gives `npc` = `pc`+4. This also holds for opcode 0x00 when the function field (bits 5:0) is not 0x08.
- R3: Opcode 0x04 gives `npc` = `pc`+4+offset when `rs_val` equals `rt_val`, and `pc`+4 otherwise.
- R4: Opcode 0x05 gives `npc` = `pc`+4+offset when `rs_val` differs from `rt_val`, and `pc`+4 otherwise.
- R5: Opcode 0x06 takes the branch when `rs_val`, read as a signed two's-complement number, is zero or negative. `rt_val` has no effect on the decision.
- R6: Opcode 0x07 takes the branch when `rs_val`, read as signed, is strictly greater than zero.
- R7: The branch offset is bits 15:0 of the instruction, sign-extended and shifted left by two. It is added modulo 2^32 to `pc`+4.
- R8: Opcodes 0x02 and 0x03 give `npc` = {(`pc`+4)[31:28], instr[25:0], 2'b00}.
- R9: Opcode 0x03 asserts `link_we` with `link_addr` = 31 and `link_data` = `pc`+4. Every other instruction leaves `link_we` low.
- R10: Opcode 0x00 with function 0x08 gives `npc` = `rs_val`, taken unchanged with all 32 bits.
- R11: Outside reset, on each rising edge `pc` takes the `npc` value presented before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction fetched from `pc` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| npc | output | 32 | Address to be loaded at the next edge |
| link_we | output | 1 | Return-address write request |
| link_addr | output | 5 | Destination register of the link write |
| link_data | output | 32 | Return address to write |

## Verification
The bench builds the block with its defaults, RESET_PC = 0 and SYNC_STAGES = 2. The two-stage release makes the reset hold-off short enough to count edge by edge. The full 32-bit PC lets the bench steer the counter anywhere through a register jump and then exercise three hard cases: a branch that wraps past the top of the address space, a jump whose upper nibble comes from a carry out of `pc`+4, and the most negative offset. The signed zero tests use the values at both edges of the signed range.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XW          = 32;
  localparam int OPW         = 6;
  localparam int FNW         = 6;
  localparam int IMMW        = 16;
  localparam int JAW         = 26;
  localparam int REGW        = 5;
  localparam int INSTR_BYTES = 4;
  localparam int WSHIFT      = 2;
  localparam int REGION_W    = XW - JAW - WSHIFT;

  localparam logic [OPW-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OPW-1:0] OP_JMP     = 6'h02;
  localparam logic [OPW-1:0] OP_JMPL    = 6'h03;
  localparam logic [OPW-1:0] OP_BREQ    = 6'h04;
  localparam logic [OPW-1:0] OP_BRNE    = 6'h05;
  localparam logic [OPW-1:0] OP_BRLEZ   = 6'h06;
  localparam logic [OPW-1:0] OP_BRGTZ   = 6'h07;
  localparam logic [FNW-1:0] FN_JREG    = 6'h08;
  localparam logic [REGW-1:0] RET_REG   = 5'd31;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_JUMP,
    FLOW_JREG
  } flow_e;

  typedef enum logic [1:0] {
    CMP_EQ,
    CMP_NE,
    CMP_LEZ,
    CMP_GTZ
  } cmp_e;

  typedef struct packed {
    flow_e flow;
    cmp_e  cmp;
    logic  link;
  } ctl_t;
endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] funct,
  output ctl_t           ctl
);
  always_comb begin
    ctl.flow = FLOW_SEQ;
    ctl.cmp  = CMP_EQ;
    ctl.link = 1'b0;
    unique case (opcode)
      OP_SPECIAL: if (funct == FN_JREG) ctl.flow = FLOW_JREG;
      OP_JMP:     ctl.flow = FLOW_JUMP;
      OP_JMPL: begin
        ctl.flow = FLOW_JUMP;
        ctl.link = 1'b1;
      end
      OP_BREQ: begin
        ctl.flow = FLOW_BRANCH;
        ctl.cmp  = CMP_EQ;
      end
      OP_BRNE: begin
        ctl.flow = FLOW_BRANCH;
        ctl.cmp  = CMP_NE;
      end
      OP_BRLEZ: begin
        ctl.flow = FLOW_BRANCH;
        ctl.cmp  = CMP_LEZ;
      end
      OP_BRGTZ: begin
        ctl.flow = FLOW_BRANCH;
        ctl.cmp  = CMP_GTZ;
      end
      default: ctl.flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  cmp_e          cmp,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic          taken
);
  logic same;
  logic is_zero;
  logic is_neg;

  // Equality is an XOR-reduce; the signed tests against zero need no adder.
  assign same    = (a == b);
  assign is_zero = ~|a;
  assign is_neg  = a[XW-1];

  always_comb begin
    unique case (cmp)
      CMP_EQ:  taken = same;
      CMP_NE:  taken = ~same;
      CMP_LEZ: taken = is_neg | is_zero;
      CMP_GTZ: taken = ~is_neg & ~is_zero;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XW-1:0]   pc,
  input  logic [IMMW-1:0] imm,
  input  logic [JAW-1:0]  jaddr,
  output logic [XW-1:0]   pc_seq,
  output logic [XW-1:0]   br_tgt,
  output logic [XW-1:0]   jmp_tgt
);
  localparam int EXT_W = XW - IMMW - WSHIFT;

  logic [XW-1:0] br_off;

  assign pc_seq  = pc + XW'(INSTR_BYTES);
  assign br_off  = {{EXT_W{imm[IMMW-1]}}, imm, {WSHIFT{1'b0}}};
  // Both adders run in parallel; the branch adder takes pc plus a folded 4.
  assign br_tgt  = pc + br_off + XW'(INSTR_BYTES);
  assign jmp_tgt = {pc_seq[XW-1 -: REGION_W], jaddr, {WSHIFT{1'b0}}};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC    = 32'h0000_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] npc,
  output logic        link_we,
  output logic [4:0]  link_addr,
  output logic [31:0] link_data
);
  logic          core_rst_n;
  ctl_t          ctl;
  logic          taken;
  logic [XW-1:0] pc_q;
  logic [XW-1:0] npc_d;
  logic [XW-1:0] pc_seq;
  logic [XW-1:0] br_tgt;
  logic [XW-1:0] jmp_tgt;

  npc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  npc_decode u_dec (
    .opcode (instr[XW-1 -: OPW]),
    .funct  (instr[FNW-1:0]),
    .ctl    (ctl)
  );

  npc_cond u_cond (
    .cmp   (ctl.cmp),
    .a     (rs_val),
    .b     (rt_val),
    .taken (taken)
  );

  npc_target u_tgt (
    .pc      (pc_q),
    .imm     (instr[IMMW-1:0]),
    .jaddr   (instr[JAW-1:0]),
    .pc_seq  (pc_seq),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  always_comb begin
    unique case (ctl.flow)
      FLOW_BRANCH: npc_d = taken ? br_tgt : pc_seq;
      FLOW_JUMP:   npc_d = jmp_tgt;
      FLOW_JREG:   npc_d = rs_val;
      default:     npc_d = pc_seq;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= RESET_PC;
    else             pc_q <= npc_d;
  end

  assign pc        = pc_q;
  assign npc       = npc_d;
  assign link_we   = ctl.link;
  assign link_addr = RET_REG;
  assign link_data = pc_seq;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        core_rst_n,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc,
  input logic [31:0] npc,
  input logic        link_we,
  input logic [4:0]  link_addr,
  input logic [31:0] link_data
);
  logic [5:0]  op;
  logic [31:0] seq_a;
  logic [31:0] br_a;
  logic        plain;

  assign op    = instr[31:26];
  assign seq_a = pc + 32'd4;
  assign br_a  = seq_a + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign plain = (op != 6'h00) && (op > 6'h07 || op == 6'h01);

  AST_RESET_PC: assert property (@(posedge clk) !rst_n |-> pc == RESET_PC); // R1
  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    plain |-> npc == seq_a); // R2
  AST_BREQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h04 && rs_val == rt_val) |-> npc == br_a); // R3
  AST_BRNE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h05 && rs_val == rt_val) |-> npc == seq_a); // R4
  AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h02 || op == 6'h03) |-> (npc[27:0] == {instr[25:0], 2'b00} && npc[31:28] == seq_a[31:28])); // R8
  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (op == 6'h03 && link_addr == 5'd31 && link_data == seq_a)); // R9
  AST_JREG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'h00 && instr[5:0] == 6'h08) |-> npc == rs_val); // R10
  AST_PC_TRACKS: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> pc == $past(npc)); // R11
endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .instr      (instr),
  .rs_val     (rs_val),
  .rt_val     (rt_val),
  .pc         (pc),
  .npc        (npc),
  .link_we    (link_we),
  .link_addr  (link_addr),
  .link_data  (link_data)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] pc;
  logic [31:0] npc;
  logic        link_we;
  logic [4:0]  link_addr;
  logic [31:0] link_data;

  int n_chk;
  int n_bad;
  bit done;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .npc(npc), .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] a);
    return {op, a};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one instruction at the falling edge, check the comb outputs,
  // then check the PC after the next rising edge.
  task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] exp_npc, input bit exp_link);
    logic [31:0] pc0;
    pc0 = pc;
    instr = ins; rs_val = a; rt_val = b;
    #1;
    check(tag, "npc", npc, exp_npc);
    check("R9", "link_we", {31'd0, link_we}, {31'd0, exp_link});
    if (exp_link) begin
      check("R9", "link_addr", {27'd0, link_addr}, 32'd31);
      check("R9", "link_data", link_data, pc0 + 32'd4);
    end
    @(posedge clk);
    @(negedge clk);
    check("R11", "pc", pc, exp_npc);
  endtask

  task automatic set_pc(input logic [31:0] a);
    run("R10", enc_r(5'd4, 5'd0, 5'd0, 6'h08), a, 32'd0, a, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b1; instr = 32'd0; rs_val = '0; rt_val = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pc, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "pc edge 1", pc, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1", "pc edge 2", pc, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1", "pc edge 3", pc, 32'd4);
  endtask

  task automatic t_seq;
    set_pc(32'h0000_0100);
    run("R2", enc_i(6'h08, 5'd1, 5'd2, 16'h0005), 32'd7, 32'd7, 32'h0000_0104, 1'b0);
    run("R2", enc_i(6'h23, 5'd1, 5'd2, 16'hFFFC), 32'd0, 32'd0, 32'h0000_0108, 1'b0);
    run("R2", enc_r(5'd1, 5'd2, 5'd3, 6'h20), 32'h55, 32'h55, 32'h0000_010C, 1'b0);
    run("R2", enc_i(6'h01, 5'd1, 5'd0, 16'h0010), 32'd0, 32'd0, 32'h0000_0110, 1'b0);
  endtask

  task automatic t_beq;
    set_pc(32'h0000_1000);
    run("R3", enc_i(6'h04, 5'd1, 5'd2, 16'h0003), 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_1010, 1'b0);
    run("R3", enc_i(6'h04, 5'd1, 5'd2, 16'h0003), 32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'h0000_1014, 1'b0);
  endtask

  task automatic t_bne;
    set_pc(32'h0000_2000);
    run("R4", enc_i(6'h05, 5'd1, 5'd2, 16'h0004), 32'h1, 32'h8000_0001, 32'h0000_2014, 1'b0);
    run("R4", enc_i(6'h05, 5'd1, 5'd2, 16'h0004), 32'h9, 32'h9, 32'h0000_2018, 1'b0);
  endtask

  task automatic t_blez;
    set_pc(32'h0000_3000);
    run("R5", enc_i(6'h06, 5'd1, 5'd7, 16'h0002), 32'h0, 32'h5, 32'h0000_300C, 1'b0);
    run("R5", enc_i(6'h06, 5'd1, 5'd7, 16'h0002), 32'hFFFF_FFFF, 32'h0, 32'h0000_3018, 1'b0);
    run("R5", enc_i(6'h06, 5'd1, 5'd7, 16'h0002), 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_3024, 1'b0);
    run("R5", enc_i(6'h06, 5'd1, 5'd7, 16'h0002), 32'h1, 32'h1, 32'h0000_3028, 1'b0);
    run("R5", enc_i(6'h06, 5'd1, 5'd7, 16'h0002), 32'h7FFF_FFFF, 32'h0, 32'h0000_302C, 1'b0);
  endtask

  task automatic t_bgtz;
    set_pc(32'h0000_4000);
    run("R6", enc_i(6'h07, 5'd1, 5'd0, 16'h0001), 32'h1, 32'h0, 32'h0000_4008, 1'b0);
    run("R6", enc_i(6'h07, 5'd1, 5'd0, 16'h0001), 32'h7FFF_FFFF, 32'h9, 32'h0000_4010, 1'b0);
    run("R6", enc_i(6'h07, 5'd1, 5'd0, 16'h0001), 32'h0, 32'h0, 32'h0000_4014, 1'b0);
    run("R6", enc_i(6'h07, 5'd1, 5'd0, 16'h0001), 32'h8000_0000, 32'h0, 32'h0000_4018, 1'b0);
  endtask

  task automatic t_offset;
    set_pc(32'h0000_2000);
    run("R7", enc_i(6'h04, 5'd0, 5'd0, 16'hFFFE), 32'd0, 32'd0, 32'h0000_1FFC, 1'b0);
    set_pc(32'h0004_0000);
    run("R7", enc_i(6'h04, 5'd0, 5'd0, 16'h8000), 32'd0, 32'd0, 32'h0002_0004, 1'b0);
    set_pc(32'hFFFF_FFF0);
    run("R7", enc_i(6'h04, 5'd0, 5'd0, 16'h0004), 32'd0, 32'd0, 32'h0000_0004, 1'b0);
  endtask

  task automatic t_jump;
    set_pc(32'h0FFF_FFFC);
    run("R8", enc_j(6'h02, 26'h000_0010), 32'd0, 32'd0, 32'h1000_0040, 1'b0);
    set_pc(32'hA000_0000);
    run("R8", enc_j(6'h02, 26'h3FF_FFFF), 32'd0, 32'd0, 32'hAFFF_FFFC, 1'b0);
  endtask

  task automatic t_call;
    set_pc(32'h0040_0020);
    run("R9", enc_j(6'h03, 26'h000_0100), 32'd0, 32'd0, 32'h0000_0400, 1'b1);
    set_pc(32'h3FFF_FFFC);
    run("R9", enc_j(6'h03, 26'h000_0001), 32'd0, 32'd0, 32'h4000_0004, 1'b1);
  endtask

  task automatic t_jreg;
    set_pc(32'h0000_0200);
    run("R10", enc_r(5'd9, 5'd0, 5'd0, 6'h08), 32'h1234_5677, 32'd0, 32'h1234_5677, 1'b0);
    run("R10", enc_r(5'd9, 5'd0, 5'd0, 6'h09), 32'h0000_0800, 32'd0, 32'h1234_567B, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    t_reset;
    t_seq;
    t_beq;
    t_bne;
    t_blez;
    t_bgtz;
    t_offset;
    t_jump;
    t_call;
    t_jreg;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule